// File: doc/BRIEF.md
# Dual-Bank Conflict-Free Data Memory

This block is a core's local data memory made of two independent banks, each with one read and one write port. Together the banks deliver two operand reads and one result write in every cycle. The design does not pay for a true three-port array. Read data is steered through a small crossbar to the operand port that asked for it, selected by the bank bit of each operand address.

Each write names its target banks: the low bank, the high bank, or both at the same word index. The compiler places a value that might be read together with another operand from the same bank into both banks. That costs one extra word but removes any chance of a collision on that value. If two reads still land on different words of one bank, operand A is served and a conflict flag is raised, so that a bench or monitor can prove the placement was clean.

Top module: `dualbank_dmem`

## Requirements
- R1: `wr_mode` is two bits, where bit 0 enables the write into bank 0 and bit 1 enables the write into bank 1. Code 2'b11 writes `wr_data` into both banks at `wr_idx`.
- R2: A read address is 8 bits. Bit 7 selects the bank and bits 6:0 select the word. Read data appears on the output in the cycle after the request, one clock edge later.
- R3: Two enabled reads that target different banks are both served in the same cycle with `rd_conflict` low.
- R4: Two enabled reads to different words of the same bank return port A's word on `rd_a_data`, zero on `rd_b_data`, and `rd_conflict` high, all in the cycle the data appears.
- R5: Two enabled reads of the identical address return the same word on both ports with `rd_conflict` low.
- R6: A port whose read enable was low outputs zero in the following cycle. `rd_conflict` is never raised unless both reads were enabled.
- R7: A read of the word being written in the same cycle returns the previous contents. The new value is returned by a read issued in the next cycle.
- R8: `wr_mode` 2'b00 leaves both banks unchanged.
- R9: After synchronous reset, both read outputs are zero and `rd_conflict` is low.
- R10: A single-bank write (2'b01 or 2'b10) leaves the same index in the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 2 | Write bank mask: bit k writes bank k |
| wr_idx | input | 7 | Word index for the write |
| wr_data | input | 16 | Write data |
| rd_a_en | input | 1 | Operand A read enable |
| rd_a_addr | input | 8 | Operand A address (bit 7 = bank) |
| rd_b_en | input | 1 | Operand B read enable |
| rd_b_addr | input | 8 | Operand B address (bit 7 = bank) |
| rd_a_data | output | 16 | Operand A data, one cycle after request |
| rd_b_data | output | 16 | Operand B data, one cycle after request |
| rd_conflict | output | 1 | Same-bank collision on the request one cycle earlier |

## Verification
The assertions check the steering rules on every cycle against the previous cycle's requests. These rules are: a conflict flag exactly for same-bank, different-word pairs; zeroed B data on a conflict; zero on disabled ports; and matching data on identical addresses. The assertions cannot see storage, so only the bench scenarios show that the write masks land in the right banks, that an idle mode or a single-bank write leaves the other bank alone, and that a same-cycle read returns the old word. Those scenarios compare against a bench-side shadow copy of both banks.

// File: rtl/dualbank_dmem_pkg.sv
package dualbank_dmem_pkg;

    localparam int DBM_WORD_W     = 16;
    localparam int DBM_BANK_WORDS = 128;
    localparam int DBM_BANKS      = 2;

    typedef enum logic [1:0] {
        WM_IDLE = 2'b00,
        WM_LOW  = 2'b01,
        WM_HIGH = 2'b10,
        WM_DUAL = 2'b11
    } wr_mode_e;

    typedef struct packed {
        logic a_vld;
        logic a_src;
        logic b_vld;
        logic b_src;
        logic clash;
    } route_t;

    function automatic route_t plan_route(
        input logic a_en,
        input logic b_en,
        input logic a_bank,
        input logic b_bank,
        input logic same_word
    );
        route_t r;
        logic   shared;
        shared  = a_en && b_en && (a_bank == b_bank);
        r.clash = shared && !same_word;
        r.a_vld = a_en;
        r.a_src = a_bank;
        r.b_vld = b_en && !r.clash;
        r.b_src = b_bank;
        return r;
    endfunction

endpackage

// File: rtl/dualbank_dmem_bank.sv
module dualbank_dmem_bank #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] cells [DEPTH];
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Read samples the array before this edge's write lands: old data wins.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= cells[rd_idx];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/dualbank_dmem_steer.sv
module dualbank_dmem_steer
    import dualbank_dmem_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              rd_a_en,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic              rd_b_en,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [1:0]        bank_rd_en,
    output logic [1:0][IDX_W-1:0] bank_rd_idx,
    output route_t            route
);
    logic a_bank;
    logic b_bank;

    assign a_bank = rd_a_addr[IDX_W];
    assign b_bank = rd_b_addr[IDX_W];

    for (genvar k = 0; k < DBM_BANKS; k++) begin : g_bank_port
        logic a_hit;
        logic b_hit;
        always_comb begin
            a_hit          = rd_a_en && (a_bank == 1'(k));
            b_hit          = rd_b_en && (b_bank == 1'(k));
            bank_rd_en[k]  = a_hit || b_hit;
            bank_rd_idx[k] = a_hit ? rd_a_addr[IDX_W-1:0] : rd_b_addr[IDX_W-1:0];
        end
    end

    always_comb begin
        route = plan_route(rd_a_en, rd_b_en, a_bank, b_bank,
                           rd_a_addr == rd_b_addr);
    end
endmodule

// File: rtl/dualbank_dmem_outmux.sv
module dualbank_dmem_outmux
    import dualbank_dmem_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  route_t                 route_in,
    input  logic [1:0][WORD_W-1:0] bank_q,
    output logic [WORD_W-1:0]      rd_a_data,
    output logic [WORD_W-1:0]      rd_b_data,
    output logic                   rd_conflict
);
    route_t route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else begin
            route_q <= route_in;
        end
    end

    always_comb begin
        rd_a_data   = route_q.a_vld ? bank_q[route_q.a_src] : '0;
        rd_b_data   = route_q.b_vld ? bank_q[route_q.b_src] : '0;
        rd_conflict = route_q.clash;
    end
endmodule

// File: rtl/dualbank_dmem.sv
module dualbank_dmem
    import dualbank_dmem_pkg::*;
#(
    parameter int WORD_W     = DBM_WORD_W,
    parameter int BANK_WORDS = DBM_BANK_WORDS,
    localparam int IDX_W     = $clog2(BANK_WORDS),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_mode,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_a_en,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic              rd_b_en,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [WORD_W-1:0] rd_a_data,
    output logic [WORD_W-1:0] rd_b_data,
    output logic              rd_conflict
);
    wr_mode_e                mode;
    logic [1:0]              bank_rd_en;
    logic [1:0][IDX_W-1:0]   bank_rd_idx;
    logic [1:0][WORD_W-1:0]  bank_q;
    route_t                  route;

    assign mode = wr_mode_e'(wr_mode);

    dualbank_dmem_steer #(.IDX_W(IDX_W)) steer_i (
        .rd_a_en    (rd_a_en),
        .rd_a_addr  (rd_a_addr),
        .rd_b_en    (rd_b_en),
        .rd_b_addr  (rd_b_addr),
        .bank_rd_en (bank_rd_en),
        .bank_rd_idx(bank_rd_idx),
        .route      (route)
    );

    for (genvar k = 0; k < DBM_BANKS; k++) begin : g_bank
        logic we;
        assign we = (mode == WM_DUAL) || (k == 0 ? mode == WM_LOW : mode == WM_HIGH);
        dualbank_dmem_bank #(.WORD_W(WORD_W), .DEPTH(BANK_WORDS)) bank_i (
            .clk    (clk),
            .wr_en  (we),
            .wr_idx (wr_idx),
            .wr_data(wr_data),
            .rd_en  (bank_rd_en[k]),
            .rd_idx (bank_rd_idx[k]),
            .rd_data(bank_q[k])
        );
    end

    dualbank_dmem_outmux #(.WORD_W(WORD_W)) outmux_i (
        .clk        (clk),
        .rst        (rst),
        .route_in   (route),
        .bank_q     (bank_q),
        .rd_a_data  (rd_a_data),
        .rd_b_data  (rd_b_data),
        .rd_conflict(rd_conflict)
    );
endmodule

// File: rtl/dualbank_dmem_chk.sv
module dualbank_dmem_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_a_en,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic              rd_b_en,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [WORD_W-1:0] rd_a_data,
    input logic [WORD_W-1:0] rd_b_data,
    input logic              rd_conflict
);
    logic armed;
    logic same_bank;
    logic both_en;

    assign same_bank = rd_a_addr[ADDR_W-1] == rd_b_addr[ADDR_W-1];
    assign both_en   = rd_a_en && rd_b_en;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_split_banks_R3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(both_en && !same_bank) |-> !rd_conflict);

    assert_clash_flag_R4: assert property (@(posedge clk) disable iff (rst)
        armed && $past(both_en && same_bank && rd_a_addr != rd_b_addr) |-> rd_conflict);

    assert_clash_b_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rd_conflict |-> rd_b_data == '0);

    assert_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
        armed && $past(both_en && rd_a_addr == rd_b_addr) |-> !rd_conflict && rd_a_data == rd_b_data);

    assert_idle_a_R6: assert property (@(posedge clk) disable iff (rst)
        armed && $past(!rd_a_en) |-> rd_a_data == '0);

    assert_idle_b_R6: assert property (@(posedge clk) disable iff (rst)
        armed && $past(!rd_b_en) |-> rd_b_data == '0);

    assert_flag_needs_both_R6: assert property (@(posedge clk) disable iff (rst)
        armed && rd_conflict |-> $past(both_en));
endmodule

bind dualbank_dmem dualbank_dmem_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_a_en    (rd_a_en),
    .rd_a_addr  (rd_a_addr),
    .rd_b_en    (rd_b_en),
    .rd_b_addr  (rd_b_addr),
    .rd_a_data  (rd_a_data),
    .rd_b_data  (rd_b_data),
    .rd_conflict(rd_conflict)
);

// File: tb/dualbank_dmem_tb_top.sv
module dualbank_dmem_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_mode = 2'b00;
    logic [6:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        rd_a_en = 1'b0;
    logic [7:0]  rd_a_addr = '0;
    logic        rd_b_en = 1'b0;
    logic [7:0]  rd_b_addr = '0;
    logic [15:0] rd_a_data;
    logic [15:0] rd_b_data;
    logic        rd_conflict;

    int total = 0;
    int bad   = 0;
    logic [15:0] model [2][128];

    always #4 clk = ~clk;

    dualbank_dmem dut_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_conflict(rd_conflict)
    );

    function automatic logic exp_clash(logic ae, logic [7:0] aa, logic be, logic [7:0] ba);
        return ae && be && (aa[7] == ba[7]) && (aa != ba);
    endfunction

    function automatic logic [15:0] exp_rd(logic en, logic [7:0] ad);
        return en ? model[ad[7]][ad[6:0]] : 16'h0;
    endfunction

    function automatic string pick_tag(logic ae, logic [7:0] aa, logic be, logic [7:0] ba);
        if (exp_clash(ae, aa, be, ba)) return "R4";
        if (ae && be && aa == ba)      return "R5";
        if (ae && be)                  return "R3";
        return "R6";
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // At a negedge: apply request, wait one edge, compare at the next negedge.
    task automatic step(string tag, logic [1:0] wm, logic [6:0] wi, logic [15:0] wd,
                        logic ae, logic [7:0] aa, logic be, logic [7:0] ba);
        logic [15:0] ea, eb;
        logic        ec;
        ec = exp_clash(ae, aa, be, ba);
        ea = exp_rd(ae, aa);
        eb = ec ? 16'h0 : exp_rd(be, ba);
        wr_mode = wm; wr_idx = wi; wr_data = wd;
        rd_a_en = ae; rd_a_addr = aa; rd_b_en = be; rd_b_addr = ba;
        @(negedge clk);
        if (wm[0]) model[0][wi] = wd;
        if (wm[1]) model[1][wi] = wd;
        check(tag, "rd_a_data", rd_a_data, ea);
        check(tag, "rd_b_data", rd_b_data, eb);
        check(tag, "rd_conflict", {15'h0, rd_conflict}, {15'h0, ec});
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "rd_a_data", rd_a_data, 16'h0);
        check("R9", "rd_b_data", rd_b_data, 16'h0);
        check("R9", "rd_conflict", {15'h0, rd_conflict}, 16'h0);
        rst = 1'b0;

        // R1: fill both banks with one dual write per index
        for (int i = 0; i < 128; i++) begin
            step("R1", 2'b11, 7'(i), 16'(16'h1000 + i), 1'b0, 8'h0, 1'b0, 8'h0);
        end
        step("R1", 2'b00, 7'h0, 16'h0, 1'b1, 8'h05, 1'b1, 8'h85);
        step("R1", 2'b00, 7'h0, 16'h0, 1'b1, 8'h7f, 1'b1, 8'hff);

        // R10: single-bank writes leave the other bank alone
        step("R10", 2'b01, 7'd9, 16'hAAAA, 1'b0, 8'h0, 1'b0, 8'h0);
        step("R10", 2'b00, 7'h0, 16'h0, 1'b1, 8'h89, 1'b1, 8'h09);
        step("R10", 2'b10, 7'd10, 16'hBBBB, 1'b0, 8'h0, 1'b0, 8'h0);
        step("R10", 2'b00, 7'h0, 16'h0, 1'b1, 8'h0a, 1'b1, 8'h8a);

        // R8: idle mode writes nothing
        step("R8", 2'b00, 7'd5, 16'hDEAD, 1'b0, 8'h0, 1'b0, 8'h0);
        step("R8", 2'b00, 7'h0, 16'h0, 1'b1, 8'h05, 1'b1, 8'h85);

        // R7: same-cycle read returns old data, next cycle new
        step("R7", 2'b01, 7'd3, 16'h7777, 1'b1, 8'h03, 1'b0, 8'h0);
        step("R7", 2'b00, 7'h0, 16'h0, 1'b1, 8'h03, 1'b0, 8'h0);

        // R2, R3: split banks, one cycle latency
        step("R3", 2'b00, 7'h0, 16'h0, 1'b1, 8'h91, 1'b1, 8'h22);
        // R4: same bank, different words
        step("R4", 2'b00, 7'h0, 16'h0, 1'b1, 8'h10, 1'b1, 8'h11);
        step("R4", 2'b00, 7'h0, 16'h0, 1'b1, 8'hc0, 1'b1, 8'hc1);
        // R5: identical address
        step("R5", 2'b00, 7'h0, 16'h0, 1'b1, 8'h44, 1'b1, 8'h44);
        // R6: disabled ports
        step("R6", 2'b00, 7'h0, 16'h0, 1'b0, 8'h10, 1'b1, 8'h11);
        step("R6", 2'b00, 7'h0, 16'h0, 1'b1, 8'h10, 1'b0, 8'h11);
        step("R6", 2'b00, 7'h0, 16'h0, 1'b0, 8'h10, 1'b0, 8'h11);

        // Random mix, including writes and R2 latency on every step
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]  wm;
            logic [7:0]  aa, ba;
            logic        ae, be;
            wm = 2'($urandom_range(0, 3));
            ae = 1'($urandom_range(0, 3) != 0);
            be = 1'($urandom_range(0, 3) != 0);
            aa = 8'($urandom);
            ba = ($urandom_range(0, 7) == 0) ? aa : 8'($urandom);
            step(pick_tag(ae, aa, be, ba), wm, 7'($urandom), 16'($urandom), ae, aa, be, ba);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule